// File: doc/BRIEF.md
# Two-Tier Priority Arbiter for DMA Channels

This block decides which of several DMA channels may use a single shared bus master port. Every channel presents a request line, an enable line and a 2-bit software priority. The arbiter picks one eligible channel and drives a one-hot grant to it. The grant stays in place until the owning channel reports, through `item_done`, that its current item transfer has finished. Only then is a new choice made. An item in flight is therefore never preempted.

The choice is made in two tiers. The programmable priority level comes first. Among the channels that share the winning level, a fixed rule then favours the lowest channel index. The channel count is a parameter. It is 7 by default, and a 5-channel instance is the second intended configuration. The channel engines and the bus itself sit outside this block. So does any arbitration between separate controllers.

Top module: `dma_prio_arbiter`

## Requirements
- R1: While `rst_n` is low, `grant` is all zeros and `busy` is low.
- R2: A channel is eligible when its request and its enable are both high. Among eligible channels, the one with the numerically highest priority field wins. Channel i's priority occupies `ch_prio[2i+1:2i]`, with 2'b11 = very high, 2'b10 = high, 2'b01 = medium and 2'b00 = low.
- R3: When several eligible channels share the highest level, the one with the lowest index wins.
- R4: A channel whose enable bit is low is never granted, even when its request bit is high.
- R5: `grant` is either all zeros or exactly one bit. `busy` is high exactly when `grant` is non-zero.
- R6: While a grant is held and `item_done` is low, the grant does not change. This holds when higher-priority requests arrive and when the owner drops its request.
- R7: On a clock edge with a grant held and `item_done` high, a new choice is made from the requests present at that edge. The result shows after that edge. If nothing is eligible, `grant` returns to zero.
- R8: While idle (`grant` all zeros), a choice is made on every clock edge. An eligible request present at an edge is granted right after it.
- R9: `item_done` has no effect while idle. With nothing eligible, `grant` stays zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| ch_req | input | CHANNELS | Per-channel transfer request |
| ch_en | input | CHANNELS | Per-channel enable; low masks the channel out |
| ch_prio | input | CHANNELS*PRIO_W | Packed per-channel priority fields, channel 0 in the low bits |
| item_done | input | 1 | The granted channel has finished its current item |
| grant | output | CHANNELS | One-hot grant, or zero when idle |
| busy | output | 1 | High while a grant is held |

## Verification
On the 5-channel configuration, the bench sweeps every priority assignment against every request pattern. This exposes a tie-break that favours the highest index. It also exposes a level compare that is inverted or that ignores one bit of the field, because either fault would grant the wrong channel in some of the patterns. A second sweep crosses every enable mask with every request pattern. It catches a design that ignores the enable and hands the port to a disabled channel. Directed sequences then cover the remaining timing faults:
- raising a very-high request under a held low-priority grant catches a design that preempts;
- dropping the owner's request catches a design that releases the grant early;
- pulsing `item_done` with no requests catches a design that keeps a stale grant after completion.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

   // Priority level encoding: larger value wins.
   typedef enum logic [1:0] {
      LVL_LOW   = 2'b00,
      LVL_MED   = 2'b01,
      LVL_HIGH  = 2'b10,
      LVL_VHIGH = 2'b11
   } prio_lvl_e;

   localparam int DEF_CHANNELS = 7;
   localparam int DEF_PRIO_W   = 2;

endpackage

// File: rtl/dma_arb_level_scan.sv
// Finds the highest priority level held by any eligible channel and
// returns the set of eligible channels at that level.
module dma_arb_level_scan #(
   parameter int CHANNELS = dma_arb_pkg::DEF_CHANNELS,
   parameter int PRIO_W   = dma_arb_pkg::DEF_PRIO_W
) (
   input  logic [CHANNELS-1:0]        elig,
   input  logic [CHANNELS*PRIO_W-1:0] prio,
   output logic [CHANNELS-1:0]        cand
);
   localparam int LEVELS = 1 << PRIO_W;

   logic [LEVELS-1:0] lvl_hit;
   logic [PRIO_W-1:0] top_lvl;

   // One OR-reduction per level.
   for (genvar l = 0; l < LEVELS; l++) begin : g_level
      logic [CHANNELS-1:0] at_lvl;
      for (genvar c = 0; c < CHANNELS; c++) begin : g_ch
         assign at_lvl[c] = elig[c] && (prio[c*PRIO_W +: PRIO_W] == PRIO_W'(l));
      end
      assign lvl_hit[l] = |at_lvl;
   end

   // Ascending scan: the last level that has a hit is the highest one.
   always_comb begin
      top_lvl = '0;
      for (int l = 0; l < LEVELS; l++) begin
         if (lvl_hit[l]) top_lvl = PRIO_W'(l);
      end
   end

   for (genvar c = 0; c < CHANNELS; c++) begin : g_cand
      assign cand[c] = elig[c] && (prio[c*PRIO_W +: PRIO_W] == top_lvl);
   end

endmodule

// File: rtl/dma_arb_tie_pick.sv
// Keeps only the lowest-index set bit of the candidate vector.
module dma_arb_tie_pick #(
   parameter int CHANNELS = dma_arb_pkg::DEF_CHANNELS
) (
   input  logic [CHANNELS-1:0] cand,
   output logic [CHANNELS-1:0] pick
);
   if (CHANNELS == 1) begin : g_single
      assign pick = cand;
   end else begin : g_chain
      logic [CHANNELS:0] seen;
      assign seen[0] = 1'b0;
      for (genvar c = 0; c < CHANNELS; c++) begin : g_bit
         assign pick[c]     = cand[c] & ~seen[c];
         assign seen[c + 1] = seen[c] | cand[c];
      end
   end

endmodule

// File: rtl/dma_arb_grant_hold.sv
// Holds the grant until the owner reports item completion.
module dma_arb_grant_hold #(
   parameter int CHANNELS = dma_arb_pkg::DEF_CHANNELS
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [CHANNELS-1:0] pick,
   input  logic                item_done,
   output logic [CHANNELS-1:0] grant_q
);
   logic idle;
   logic load;

   assign idle = (grant_q == '0);
   assign load = idle || item_done;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         grant_q <= '0;
      end else if (load) begin
         grant_q <= pick;
      end
   end

endmodule

// File: rtl/dma_prio_arbiter.sv
module dma_prio_arbiter #(
   parameter int CHANNELS = dma_arb_pkg::DEF_CHANNELS,
   parameter int PRIO_W   = dma_arb_pkg::DEF_PRIO_W
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [CHANNELS-1:0]         ch_req,
   input  logic [CHANNELS-1:0]         ch_en,
   input  logic [CHANNELS*PRIO_W-1:0]  ch_prio,
   input  logic                        item_done,
   output logic [CHANNELS-1:0]         grant,
   output logic                        busy
);
   // Elaboration-time parameter checks.
   if (CHANNELS < 1 || CHANNELS > 64) begin : g_bad_channels
      $error("dma_prio_arbiter: CHANNELS must be 1..64");
   end
   if (PRIO_W < 1 || PRIO_W > 4) begin : g_bad_prio_w
      $error("dma_prio_arbiter: PRIO_W must be 1..4");
   end

   logic [CHANNELS-1:0] elig;
   logic [CHANNELS-1:0] cand;
   logic [CHANNELS-1:0] pick;
   logic [CHANNELS-1:0] grant_q;

   assign elig = ch_req & ch_en;

   dma_arb_level_scan #(.CHANNELS(CHANNELS), .PRIO_W(PRIO_W)) u_scan (
      .elig (elig),
      .prio (ch_prio),
      .cand (cand)
   );

   dma_arb_tie_pick #(.CHANNELS(CHANNELS)) u_tie (
      .cand (cand),
      .pick (pick)
   );

   dma_arb_grant_hold #(.CHANNELS(CHANNELS)) u_hold (
      .clk       (clk),
      .rst_n     (rst_n),
      .pick      (pick),
      .item_done (item_done),
      .grant_q   (grant_q)
   );

   assign grant = grant_q;
   assign busy  = |grant_q;

endmodule

// File: rtl/dma_prio_arbiter_chk.sv
module dma_prio_arbiter_chk #(
   parameter int CHANNELS = dma_arb_pkg::DEF_CHANNELS,
   parameter int PRIO_W   = dma_arb_pkg::DEF_PRIO_W
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic [CHANNELS-1:0]         ch_req,
   input logic [CHANNELS-1:0]         ch_en,
   input logic [CHANNELS*PRIO_W-1:0]  ch_prio,
   input logic                        item_done,
   input logic [CHANNELS-1:0]         grant,
   input logic                        busy
);
   // Reference pick built as a single strict-compare scan.
   logic [CHANNELS-1:0] ref_pick;
   logic [CHANNELS-1:0] live;
   logic                decide;

   assign live   = ch_req & ch_en;
   assign decide = (grant == '0) || item_done;

   always_comb begin
      logic              found;
      logic [PRIO_W-1:0] best;
      int                idx;
      found    = 1'b0;
      best     = '0;
      idx      = 0;
      ref_pick = '0;
      for (int c = 0; c < CHANNELS; c++) begin
         if (live[c] && (!found || ch_prio[c*PRIO_W +: PRIO_W] > best)) begin
            found = 1'b1;
            best  = ch_prio[c*PRIO_W +: PRIO_W];
            idx   = c;
         end
      end
      if (found) ref_pick[idx] = 1'b1;
   end

   // R5: never more than one grant bit.
   a_r5_onehot_grant: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));

   // R5: busy follows grant.
   a_r5_busy_tracks: assert property (@(posedge clk) disable iff (!rst_n)
      busy == (grant != '0));

   // R2, R3, R7, R8: the decision matches the reference choice.
   a_r2_r3_pick: assert property (@(posedge clk) disable iff (!rst_n)
      decide |=> grant == $past(ref_pick));

   // R4: a new grant only goes to a channel that was requesting and enabled.
   a_r4_masked: assert property (@(posedge clk) disable iff (!rst_n)
      decide |=> (grant & ~$past(live)) == '0);

   // R6: no change while held and not done.
   a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (grant != '0 && !item_done) |=> $stable(grant));

   // R9: idle with nothing eligible stays idle.
   a_r9_idle_stays: assert property (@(posedge clk) disable iff (!rst_n)
      (grant == '0 && live == '0) |=> grant == '0);

endmodule

bind dma_prio_arbiter dma_prio_arbiter_chk #(
   .CHANNELS (CHANNELS),
   .PRIO_W   (PRIO_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ch_req    (ch_req),
   .ch_en     (ch_en),
   .ch_prio   (ch_prio),
   .item_done (item_done),
   .grant     (grant),
   .busy      (busy)
);

// File: tb/dma_prio_arbiter_test.sv
`timescale 1ns/1ps
module dma_prio_arbiter_test;
   localparam int CH = 5;
   localparam int PW = 2;

   logic              clk = 1'b0;
   logic              rst_n;
   logic [CH-1:0]     ch_req;
   logic [CH-1:0]     ch_en;
   logic [CH*PW-1:0]  ch_prio;
   logic              item_done;
   logic [CH-1:0]     grant;
   logic              busy;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   dma_prio_arbiter #(.CHANNELS(CH), .PRIO_W(PW)) uut (
      .clk (clk), .rst_n (rst_n), .ch_req (ch_req), .ch_en (ch_en),
      .ch_prio (ch_prio), .item_done (item_done), .grant (grant), .busy (busy)
   );

   // Bench model: highest level first, then lowest index.
   function automatic logic [CH-1:0] model(input logic [CH-1:0] r,
                                           input logic [CH-1:0] e,
                                           input logic [CH*PW-1:0] p);
      int best_lvl = -1;
      int best_idx = -1;
      logic [CH-1:0] res = '0;
      for (int c = 0; c < CH; c++) begin
         int lvl = int'(p[c*PW +: PW]);
         if (r[c] && e[c] && lvl > best_lvl) begin
            best_lvl = lvl;
            best_idx = c;
         end
      end
      if (best_idx >= 0) res[best_idx] = 1'b1;
      return res;
   endfunction

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic check(input string tag, input logic [CH-1:0] exp);
      checks++;
      if (grant !== exp || busy !== (exp != '0)) begin
         errors++;
         $display("FAIL %s: grant=%b busy=%b expected grant=%b busy=%b",
                  tag, grant, busy, exp, (exp != '0));
      end
   endtask

   task automatic drive(input logic [CH-1:0] r, input logic [CH-1:0] e,
                        input logic [CH*PW-1:0] p, input logic d);
      ch_req = r; ch_en = e; ch_prio = p; item_done = d;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog: run did not complete");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [CH*PW-1:0] fixed_p;
      rst_n = 1'b0;
      drive('1, '1, '1, 1'b0);
      repeat (3) @(negedge clk);
      check("R1 reset", '0);
      rst_n = 1'b1;
      drive('0, '1, '0, 1'b0);
      step();
      check("R1 after reset", '0);

      // Full sweep: every priority map crossed with every request pattern.
      for (int p = 0; p < (1 << (CH*PW)); p++) begin
         for (int r = 0; r < (1 << CH); r++) begin
            drive(CH'(r), '1, (CH*PW)'(p), 1'b0);
            step();
            check("R2 R3 R8 sweep", model(CH'(r), '1, (CH*PW)'(p)));
            drive('0, '1, (CH*PW)'(p), 1'b1);
            step();
            check("R7 release to idle", '0);
         end
      end

      // Enable masks crossed with request patterns.
      fixed_p = {2'b00, 2'b11, 2'b01, 2'b11, 2'b10};
      for (int e = 0; e < (1 << CH); e++) begin
         for (int r = 0; r < (1 << CH); r++) begin
            drive(CH'(r), CH'(e), fixed_p, 1'b0);
            step();
            check("R4 enable mask", model(CH'(r), CH'(e), fixed_p));
            drive('0, '1, fixed_p, 1'b1);
            step();
         end
      end

      // Hold and re-arbitration: ch2 low, ch0 very high.
      fixed_p = {2'b00, 2'b11, 2'b00, 2'b00, 2'b11};
      drive(5'b00100, '1, fixed_p, 1'b0);
      step();
      check("R8 low-priority owner", 5'b00100);
      drive(5'b00101, '1, fixed_p, 1'b0);
      for (int k = 0; k < 3; k++) begin
         step();
         check("R6 no preemption", 5'b00100);
      end
      drive(5'b00001, '1, fixed_p, 1'b0);
      step();
      check("R6 owner drops request", 5'b00100);
      drive(5'b01001, '1, fixed_p, 1'b1);
      step();
      check("R7 re-arbitrate on done", 5'b00001);
      drive(5'b01001, '1, fixed_p, 1'b1);
      step();
      check("R7 R3 back-to-back tie", 5'b00001);
      drive(5'b01000, '1, fixed_p, 1'b1);
      step();
      check("R7 next owner", 5'b01000);
      drive('0, '1, fixed_p, 1'b1);
      step();
      check("R7 done with none pending", '0);
      drive('0, '1, fixed_p, 1'b1);
      step();
      check("R9 done while idle", '0);
      drive(5'b10000, 5'b01111, fixed_p, 1'b1);
      step();
      check("R9 R4 disabled only", '0);
      drive(5'b10010, '1, fixed_p, 1'b1);
      step();
      check("R9 R2 idle done ignored", 5'b00010);

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule